// File: doc/BRIEF.md
# Eight-Channel DAC Serial Command Register File

This block is the digital control core of an eight-channel voltage DAC. Channels 0 to 3 hold 16-bit codes and channels 4 to 7 hold 12-bit codes. A host sends 32-bit command frames over a three-wire serial link: an active-low frame select, a serial clock and a data line. The shift logic runs on the serial clock. Once a frame is complete, a level flag crosses into the system clock domain through a two-flop synchronizer. There it is turned into a one-cycle strobe, and the strobe applies the decoded command to the register file.

Each channel is double-buffered. A staging register takes new codes, and an output register drives the analog converter. Data moves from staging to output in three ways: by command, by a hardware load pin (level-sensitive, active low, with a per-channel mask that lets a channel ignore the pin), or through a falling edge on a clear pin. The clear pin loads a programmable clear value into both registers of every channel. Other commands set the per-channel power-down load selection, the clear value, the mask and the internal reference enable, and one command restores the reset state.

Top module: `octdac_core`

## Requirements
- R1: After reset, every channel output code is 0, every power-down field is 00, the reference enable is 0, the load mask is 0 and the clear selection is zero scale.
- R2: A frame is 32 bits, sampled on rising `sclk` edges while `sync_n` is low, most significant bit first. Bits 27:24 hold the command, bits 23:20 the channel address and bits 19:4 a 16-bit code. Bits 31:28 have no effect.
- R3: If `sync_n` rises after fewer than 32 bits, the frame changes no output.
- R4: Command 0 writes only the staging register of the addressed channel; its output code stays unchanged.
- R5: Command 1 copies staging to output for the addressed channel. Command 3 writes staging and output of the addressed channel. Command 2 writes the addressed staging register and then copies staging to output on all eight channels.
- R6: Address values 0 to 7 select channel 0 to 7. Address 15 selects all channels. Addresses 8 to 14 select none.
- R7: Channels 4 to 7 take frame bits 19:8 as their 12-bit code and report it zero-extended, with bits 15:12 of their output slice equal to 0.
- R8: Command 4 writes the 2-bit mode in frame bits 9:8 into each channel whose bit is set in frame bits 7:0 (bit i selects channel i). Other channels keep their mode.
- R9: Command 5 selects the clear value from frame bits 1:0: 00 is zero, 01 is midscale (MSB only), 10 is full scale, and 11 leaves the selection unchanged. A falling edge on `clr_n` loads the selected value into the staging and output registers of every channel, including while a frame is being shifted. That frame still applies afterwards.
- R10: While `ldac_n` is low, every channel whose mask bit is 0 copies staging to output. Command 6 sets the mask from frame bits 7:0, and a channel with mask bit 1 ignores the pin.
- R11: Command 8 sets the reference enable to frame bit 0.
- R12: Command 7 returns all registers to the R1 state.
- R13: Commands 9 to 15 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data |
| ldac_n | input | 1 | Active-low hardware load |
| clr_n | input | 1 | Clear request, falling-edge triggered |
| dac_code_o | output | 128 | Channel i output code in bits 16i+15:16i |
| pd_mode_o | output | 16 | Channel i power-down mode in bits 2i+1:2i |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
A completed frame raises its flag on the 32nd serial edge. The flag passes two synchronizer flops and then the edge detector, so the command's effect appears after the third system edge. A `clr_n` fall and a low `ldac_n` pass through two flops as well and act on the third edge. Each stimulus is followed by eight system cycles of settling, and outputs are then sampled on a falling clock edge. In this way every check reads a value that is stable and final, never one that is still moving through the synchronizers. Between stimuli the checker asserts that outputs hold when no strobe, clear or load is active.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    localparam int NUM_CH      = 8;
    localparam int WIDE_CH     = 4;
    localparam int WIDE_W      = 16;
    localparam int NARROW_W    = 12;
    localparam int OUT_W       = WIDE_W;
    localparam int PD_W        = 2;
    localparam int FRAME_W     = 32;
    localparam int BITCNT_W    = $clog2(FRAME_W) + 1;
    localparam int SYNC_STAGES = 2;

    localparam int CMD_LSB  = 24;
    localparam int ADDR_LSB = 20;
    localparam int CODE_LSB = 4;
    localparam int PDM_LSB  = 8;

    localparam logic [3:0] ADDR_ALL = 4'hF;

    typedef enum logic [3:0] {
        CMD_WR_IN      = 4'd0,
        CMD_UPD        = 4'd1,
        CMD_WR_UPD_ALL = 4'd2,
        CMD_WR_UPD     = 4'd3,
        CMD_PWR        = 4'd4,
        CMD_CLR_CODE   = 4'd5,
        CMD_MASK       = 4'd6,
        CMD_SOFT_RST   = 4'd7,
        CMD_REF        = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        CLR_ZERO = 2'd0,
        CLR_MID  = 2'd1,
        CLR_FULL = 2'd2,
        CLR_KEEP = 2'd3
    } clr_sel_e;

    typedef struct packed {
        logic              valid;
        cmd_e              op;
        logic [3:0]        addr;
        logic [WIDE_W-1:0] code;
        logic [PD_W-1:0]   pd_mode;
        logic [NUM_CH-1:0] ch_bits;
        clr_sel_e          clr_sel;
        logic              ref_on;
    } frame_t;

    function automatic int chan_width(input int idx);
        return (idx < WIDE_CH) ? WIDE_W : NARROW_W;
    endfunction

    function automatic frame_t decode_frame(input logic [FRAME_W-1:0] f);
        frame_t d;
        d.valid   = (f[CMD_LSB +: 4] <= 4'd8);
        d.op      = cmd_e'(f[CMD_LSB +: 4]);
        d.addr    = f[ADDR_LSB +: 4];
        d.code    = f[CODE_LSB +: WIDE_W];
        d.pd_mode = f[PDM_LSB +: PD_W];
        d.ch_bits = f[NUM_CH-1:0];
        d.clr_sel = clr_sel_e'(f[1:0]);
        d.ref_on  = f[0];
        return d;
    endfunction

    function automatic logic [OUT_W-1:0] clear_code(input clr_sel_e s, input int w);
        logic [OUT_W-1:0] v;
        case (s)
            CLR_MID:  v = OUT_W'(32'd1 << (w - 1));
            CLR_FULL: v = OUT_W'((32'd1 << w) - 32'd1);
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/octdac_sync.sv
module octdac_sync
    import octdac_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [SYNC_STAGES-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= {SYNC_STAGES{RST_VAL}};
        end else begin
            st_q <= {st_q[SYNC_STAGES-2:0], d};
        end
    end

    assign q = st_q[SYNC_STAGES-1];
endmodule

// File: rtl/octdac_shift.sv
module octdac_shift
    import octdac_pkg::*;
(
    input  logic               sclk,
    input  logic               arst,
    input  logic               sync_n,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_o,
    output logic               flag_o
);
    logic [FRAME_W-2:0]  sh_q;
    logic [FRAME_W-1:0]  hold_q;
    logic [BITCNT_W-1:0] cnt_q;
    logic                done_q;
    logic                last_bit;

    assign last_bit = (cnt_q == BITCNT_W'(FRAME_W - 1));

    // bit counter and completion flag, cleared whenever the frame select is high
    always_ff @(posedge sclk or posedge arst) begin
        if (arst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (cnt_q != BITCNT_W'(FRAME_W)) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) begin
                done_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge sclk) begin
        sh_q <= {sh_q[FRAME_W-3:0], din};
        if (last_bit && !sync_n) begin
            hold_q <= {sh_q, din};
        end
    end

    assign frame_o = hold_q;
    assign flag_o  = done_q & ~sync_n;
endmodule

// File: rtl/octdac_chan.sv
module octdac_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wipe,
    input  logic         clr_load,
    input  logic [W-1:0] clr_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         upd_en,
    input  logic         ldac_en,
    output logic [W-1:0] dac_q
);
    logic [W-1:0] in_q;
    logic [W-1:0] dac_r;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            in_q  <= '0;
            dac_r <= '0;
        end else if (clr_load) begin
            in_q  <= clr_val;
            dac_r <= clr_val;
        end else begin
            if (wr_en) begin
                in_q <= wr_val;
            end
            if (upd_en) begin
                dac_r <= wr_en ? wr_val : in_q;
            end else if (ldac_en) begin
                dac_r <= in_q;
            end
        end
    end

    assign dac_q = dac_r;
endmodule

// File: rtl/octdac_core.sv
module octdac_core
    import octdac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk,
    input  logic                    sync_n,
    input  logic                    din,
    input  logic                    ldac_n,
    input  logic                    clr_n,
    output logic [NUM_CH*OUT_W-1:0] dac_code_o,
    output logic [NUM_CH*PD_W-1:0]  pd_mode_o,
    output logic                    ref_en_o
);
    logic               ser_arst;
    logic [FRAME_W-1:0] frame_hold;
    logic               frame_flag;
    logic               fr_s, fr_d;
    logic               clr_s, clr_d;
    logic               ldac_s;
    logic               strobe, clr_fall, ldac_low, go, wipe;
    frame_t             cmd;

    logic [PD_W-1:0]    pd_q [NUM_CH];
    logic [NUM_CH-1:0]  mask_q;
    clr_sel_e           clr_sel_q;
    logic               ref_q;

    assign ser_arst = sync_n | rst;

    octdac_shift u_shift (
        .sclk    (sclk),
        .arst    (ser_arst),
        .sync_n  (sync_n),
        .din     (din),
        .frame_o (frame_hold),
        .flag_o  (frame_flag)
    );

    octdac_sync #(.RST_VAL(1'b0)) u_sync_fr   (.clk(clk), .rst(rst), .d(frame_flag), .q(fr_s));
    octdac_sync #(.RST_VAL(1'b1)) u_sync_clr  (.clk(clk), .rst(rst), .d(clr_n),      .q(clr_s));
    octdac_sync #(.RST_VAL(1'b1)) u_sync_ldac (.clk(clk), .rst(rst), .d(ldac_n),     .q(ldac_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_d  <= 1'b0;
            clr_d <= 1'b1;
        end else begin
            fr_d  <= fr_s;
            clr_d <= clr_s;
        end
    end

    assign strobe   = fr_s & ~fr_d;
    assign clr_fall = clr_d & ~clr_s;
    assign ldac_low = ~ldac_s;

    assign cmd  = decode_frame(frame_hold);
    assign go   = strobe & cmd.valid;
    assign wipe = go && (cmd.op == CMD_SOFT_RST);

    // control registers
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            for (int i = 0; i < NUM_CH; i++) begin
                pd_q[i] <= '0;
            end
            mask_q    <= '0;
            clr_sel_q <= CLR_ZERO;
            ref_q     <= 1'b0;
        end else if (go) begin
            case (cmd.op)
                CMD_PWR: begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        if (cmd.ch_bits[i]) begin
                            pd_q[i] <= cmd.pd_mode;
                        end
                    end
                end
                CMD_CLR_CODE: begin
                    if (cmd.clr_sel != CLR_KEEP) begin
                        clr_sel_q <= cmd.clr_sel;
                    end
                end
                CMD_MASK: mask_q <= cmd.ch_bits;
                CMD_REF:  ref_q  <= cmd.ref_on;
                default: ;
            endcase
        end
    end

    assign ref_en_o = ref_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int CW = chan_width(i);
        logic          hit;
        logic          wr;
        logic          upd;
        logic [CW-1:0] q;

        assign hit = (cmd.addr == 4'(i)) || (cmd.addr == ADDR_ALL);
        assign wr  = go && hit && (cmd.op == CMD_WR_IN || cmd.op == CMD_WR_UPD
                                   || cmd.op == CMD_WR_UPD_ALL);
        assign upd = go && ((hit && (cmd.op == CMD_UPD || cmd.op == CMD_WR_UPD))
                            || cmd.op == CMD_WR_UPD_ALL);

        octdac_chan #(.W(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wipe     (wipe),
            .clr_load (clr_fall),
            .clr_val  (CW'(clear_code(clr_sel_q, CW))),
            .wr_en    (wr),
            .wr_val   (cmd.code[WIDE_W-1 -: CW]),
            .upd_en   (upd),
            .ldac_en  (ldac_low && !mask_q[i]),
            .dac_q    (q)
        );

        assign dac_code_o[i*OUT_W +: OUT_W] = OUT_W'(q);
        assign pd_mode_o[i*PD_W +: PD_W]    = pd_q[i];
    end
endmodule

// File: rtl/octdac_core_chk.sv
module octdac_core_chk
    import octdac_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    strobe,
    input logic                    clr_fall,
    input logic                    ldac_low,
    input clr_sel_e                clr_sel_q,
    input logic [NUM_CH*OUT_W-1:0] dac_code_o,
    input logic [NUM_CH*PD_W-1:0]  pd_mode_o,
    input logic                    ref_en_o
);
    clr_sel_e                sel_prev;
    logic [NUM_CH*OUT_W-1:0] clr_bus;

    always_ff @(posedge clk) begin
        if (rst) sel_prev <= CLR_ZERO;
        else     sel_prev <= clr_sel_q;
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            clr_bus[i*OUT_W +: OUT_W] = clear_code(sel_prev, chan_width(i));
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dac_code_o == '0 && pd_mode_o == '0 && !ref_en_o));

    p_code_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !clr_fall && !ldac_low) |=> $stable(dac_code_o));

    p_pd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(pd_mode_o));

    p_clear_load_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_fall && !strobe) |=> (dac_code_o == clr_bus));

    p_ref_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(ref_en_o));
endmodule

bind octdac_core octdac_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .clr_fall   (clr_fall),
    .ldac_low   (ldac_low),
    .clr_sel_q  (clr_sel_q),
    .dac_code_o (dac_code_o),
    .pd_mode_o  (pd_mode_o),
    .ref_en_o   (ref_en_o)
);

// File: tb/octdac_core_tb.sv
module octdac_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SCLK_HALF  = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         sync_n = 1'b1;
    logic         din = 1'b0;
    logic         ldac_n = 1'b1;
    logic         clr_n = 1'b1;
    logic [127:0] dac_code_o;
    logic [15:0]  pd_mode_o;
    logic         ref_en_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] exp_in  [8];
    logic [15:0] exp_dac [8];
    logic [1:0]  exp_pd  [8];
    logic        exp_ref;
    logic [7:0]  exp_mask;
    logic [1:0]  exp_clr;

    always #(CLK_PERIOD/2) clk = ~clk;

    octdac_core u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .din(din),
        .ldac_n(ldac_n), .clr_n(clr_n),
        .dac_code_o(dac_code_o), .pd_mode_o(pd_mode_o), .ref_en_o(ref_en_o)
    );

    function automatic logic [15:0] trunc(input int ch, input logic [15:0] v);
        return (ch < 4) ? v : {4'h0, v[15:4]};
    endfunction

    function automatic logic [15:0] clr_value(input int ch, input logic [1:0] s);
        int w = (ch < 4) ? 16 : 12;
        if (s == 2'd1) return 16'(32'd1 << (w - 1));
        if (s == 2'd2) return 16'((32'd1 << w) - 1);
        return 16'h0;
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] dc, input logic [3:0] c,
                                       input logic [3:0] a, input logic [19:0] p);
        return {dc, c, a, p};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int ch = 0; ch < 8; ch++) begin
            check(req, $sformatf("code ch%0d", ch), dac_code_o[ch*16 +: 16], exp_dac[ch]);
            check(req, $sformatf("pd ch%0d", ch), 16'(pd_mode_o[ch*2 +: 2]), 16'(exp_pd[ch]));
        end
        check(req, "ref", 16'(ref_en_o), 16'(exp_ref));
    endtask

    task automatic model_reset();
        for (int ch = 0; ch < 8; ch++) begin
            exp_in[ch] = '0; exp_dac[ch] = '0; exp_pd[ch] = '0;
        end
        exp_ref = 1'b0; exp_mask = '0; exp_clr = '0;
    endtask

    task automatic model_clear();
        for (int ch = 0; ch < 8; ch++) begin
            exp_in[ch]  = clr_value(ch, exp_clr);
            exp_dac[ch] = exp_in[ch];
        end
    endtask

    task automatic model_frame(input logic [31:0] f);
        logic [3:0]  c = f[27:24];
        logic [3:0]  a = f[23:20];
        logic [15:0] code = f[19:4];
        for (int ch = 0; ch < 8; ch++) begin
            logic hit = (a == 4'(ch)) || (a == 4'hF);
            if (hit && (c == 0 || c == 2 || c == 3)) exp_in[ch] = trunc(ch, code);
            if (hit && (c == 1 || c == 3)) exp_dac[ch] = exp_in[ch];
            if (c == 4 && f[ch]) exp_pd[ch] = f[9:8];
        end
        if (c == 2) for (int ch = 0; ch < 8; ch++) exp_dac[ch] = exp_in[ch];
        if (c == 5 && f[1:0] != 2'd3) exp_clr = f[1:0];
        if (c == 6) exp_mask = f[7:0];
        if (c == 7) model_reset();
        if (c == 8) exp_ref = f[0];
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr_n = 1'b0;
        repeat (4) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_ldac();
        @(negedge clk) ldac_n = 1'b0;
        repeat (5) @(negedge clk);
        ldac_n = 1'b1;
        for (int ch = 0; ch < 8; ch++) if (!exp_mask[ch]) exp_dac[ch] = exp_in[ch];
        settle();
    endtask

    task automatic xfer(input logic [31:0] f, input int nbits, input int clr_at);
        sync_n = 1'b0;
        #(SCLK_HALF);
        for (int k = 0; k < nbits; k++) begin
            din = f[31-k];
            if (k == clr_at) pulse_clr();
            #(SCLK_HALF) sclk = 1'b1;
            #(SCLK_HALF) sclk = 1'b0;
        end
        #(5*CLK_PERIOD) sync_n = 1'b1;
        settle();
    endtask

    task automatic send(input logic [31:0] f);
        xfer(f, 32, -1);
        model_frame(f);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_bad++;
        $display("FAIL R2 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        settle();
        check_all("R1");

        // R4, R5, R7: write then update each channel
        for (int ch = 0; ch < 8; ch++) begin
            logic [15:0] v = 16'hA5C3 ^ (16'(ch) * 16'h1111);
            send(mk(4'h0, 4'd0, 4'(ch), {v, 4'h0}));
            check_all("R4");
            send(mk(4'h0, 4'd1, 4'(ch), 20'h0));
            check("R7", $sformatf("code ch%0d", ch), dac_code_o[ch*16 +: 16], trunc(ch, v));
            check_all("R5");
        end

        // R6: all-channel address, full scale
        send(mk(4'h0, 4'd3, 4'hF, {16'hFFFF, 4'h0}));
        check("R7", "narrow full", dac_code_o[7*16 +: 16], 16'h0FFF);
        check_all("R6");
        // R6: unused address selects nothing
        send(mk(4'h0, 4'd3, 4'd9, {16'h1234, 4'h0}));
        check_all("R6");

        // R5: write one channel, update all
        send(mk(4'h0, 4'd0, 4'd2, {16'h2222, 4'h0}));
        send(mk(4'h0, 4'd2, 4'd5, {16'h5A5A, 4'h0}));
        check_all("R5");

        // R3: aborted frames at several lengths
        xfer(mk(4'h0, 4'd3, 4'hF, 20'h0), 20, -1);
        check_all("R3");
        xfer(mk(4'h0, 4'd3, 4'hF, 20'h0), 31, -1);
        check_all("R3");

        // R2: don't-care high bits
        send(mk(4'hF, 4'd3, 4'd1, {16'hBEEF, 4'hF}));
        check_all("R2");

        // R8: power-down on subsets, every mode
        send(mk(4'h0, 4'd4, 4'h0, {10'h0, 2'b10, 8'b1010_0101}));
        check_all("R8");
        for (int m = 0; m < 4; m++) begin
            send(mk(4'h0, 4'd4, 4'h0, {10'h0, 2'(m), 8'(1 << m)}));
            check_all("R8");
        end

        // R9: clear values
        for (int s = 0; s < 3; s++) begin
            send(mk(4'h0, 4'd5, 4'h0, 20'(s)));
            pulse_clr();
            model_clear();
            settle();
            check_all("R9");
            send(mk(4'h0, 4'd1, 4'hF, 20'h0));
            check_all("R9");
        end
        send(mk(4'h0, 4'd5, 4'h0, 20'h3));
        send(mk(4'h0, 4'd3, 4'hF, {16'h0101, 4'h0}));
        pulse_clr();
        model_clear();
        settle();
        check("R9", "keep sel ch0", dac_code_o[15:0], 16'hFFFF);
        check_all("R9");

        // R9: clear during a frame, frame still lands afterwards
        send(mk(4'h0, 4'd5, 4'h0, 20'h1));
        xfer(mk(4'h0, 4'd3, 4'd0, {16'h1234, 4'h0}), 32, 16);
        model_clear();
        model_frame(mk(4'h0, 4'd3, 4'd0, {16'h1234, 4'h0}));
        check_all("R9");

        // R10: load pin with partial mask
        send(mk(4'h0, 4'd6, 4'h0, 20'hF0));
        send(mk(4'h0, 4'd0, 4'hF, {16'h7E81, 4'h0}));
        check_all("R4");
        pulse_ldac();
        check_all("R10");
        send(mk(4'h0, 4'd6, 4'h0, 20'h00));
        pulse_ldac();
        check_all("R10");

        // R11: reference enable
        send(mk(4'h0, 4'd8, 4'h0, 20'h1));
        check_all("R11");
        send(mk(4'h0, 4'd8, 4'h0, 20'h0));
        check_all("R11");
        send(mk(4'h0, 4'd8, 4'h0, 20'h1));

        // R13: unused commands
        for (int c = 9; c < 16; c++) begin
            send(mk(4'h0, 4'(c), 4'hF, 20'hFFFFF));
            check_all("R13");
        end

        // R12: soft reset
        send(mk(4'h0, 4'd6, 4'h0, 20'hFF));
        send(mk(4'h0, 4'd7, 4'h0, 20'h0));
        check_all("R12");
        send(mk(4'h0, 4'd0, 4'hF, {16'h4444, 4'h0}));
        pulse_ldac();
        check_all("R12");

        summary();
        $finish;
    end
endmodule